// File: doc/BRIEF.md
# Redundant Stream Memory Checker

This block sits between one memory port and two copies of the same program that run as redundant instruction streams. The leading copy is the only one that reads memory. Each value it reads is recorded, together with its address, in a load replay queue. The trailing copy later takes its load data from that queue, so both copies see the same value even if memory has changed in between.

Leading stores are parked in a store holding queue and never reach memory on their own. When the trailing copy issues the same store, its address and data are compared with the oldest parked store. Only a matching store is written to memory. Leading branch outcomes are queued as well, and the trailing copy receives them as exact predictions. Any disagreement on a load address, a store, or a branch sets a sticky error flag that stays set until reset.

Each stream sees a single stall output. A stalled stream has none of its offered operations accepted in that cycle.

Top module: `rsm_checker`

## Requirements
- R1: A leading load that is accepted drives `mem_rd_en` high with `mem_addr` equal to its address. `lead_ld_data` returns `mem_rdata` in the same cycle. Only leading loads ever raise `mem_rd_en`.
- R2: Each accepted leading load records its address and its returned data. Trailing loads receive the recorded data on `trail_ld_data`, in issue order, regardless of later changes to memory contents.
- R3: A leading store never raises `mem_wr_en`. Only an accepted trailing store whose address and data both equal the oldest held leading store writes memory, with that address and data, in the cycle it is accepted.
- R4: A trailing store whose address or data differs from the oldest held store is not written. The held entry is discarded, and `mismatch_err` is 1 from the next cycle.
- R5: Leading branch outcomes (taken bit and target) are queued in order. While the queue holds an entry, its oldest outcome is presented on `trail_br_pred_taken` and `trail_br_pred_target`.
- R6: A trailing branch whose taken bit or target differs from the oldest queued outcome sets `mismatch_err` from the next cycle.
- R7: A trailing load whose address differs from the address recorded with the oldest replay entry sets `mismatch_err` from the next cycle. It still receives the recorded data.
- R8: Each queue holds DEPTH (default 8) entries. `lead_stall` is 1 when the leading stream offers an operation whose queue is full. While stalled, nothing from that stream is accepted.
- R9: `trail_stall` is 1 when the trailing stream offers an operation whose queue is empty. While stalled, nothing from that stream is accepted or popped.
- R10: After reset `mismatch_err`, `mem_rd_en`, `mem_wr_en` and both stalls are 0 and all queues are empty. Once set, `mismatch_err` stays 1 until reset.
- R11: An accepted trailing store owns the memory port for its cycle. A leading load offered in that cycle sees `lead_stall` = 1, so read and write enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_ld_valid | input | 1 | Leading load offered |
| lead_ld_addr | input | ADDR_W | Leading load address |
| lead_ld_data | output | DATA_W | Data returned to the leading load |
| lead_st_valid | input | 1 | Leading store offered |
| lead_st_addr | input | ADDR_W | Leading store address |
| lead_st_data | input | DATA_W | Leading store data |
| lead_br_valid | input | 1 | Leading branch outcome offered |
| lead_br_taken | input | 1 | Leading branch taken |
| lead_br_target | input | ADDR_W | Leading branch target |
| lead_stall | output | 1 | Leading stream must hold its operations |
| trail_ld_valid | input | 1 | Trailing load offered |
| trail_ld_addr | input | ADDR_W | Trailing load address |
| trail_ld_data | output | DATA_W | Replayed load data for the trailing stream |
| trail_st_valid | input | 1 | Trailing store offered |
| trail_st_addr | input | ADDR_W | Trailing store address |
| trail_st_data | input | DATA_W | Trailing store data |
| trail_br_valid | input | 1 | Trailing branch resolved |
| trail_br_taken | input | 1 | Trailing branch taken |
| trail_br_target | input | ADDR_W | Trailing branch target |
| trail_br_pred_taken | output | 1 | Predicted taken bit from the oldest queued outcome |
| trail_br_pred_target | output | ADDR_W | Predicted target from the oldest queued outcome |
| trail_stall | output | 1 | Trailing stream must hold its operations |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| mismatch_err | output | 1 | Sticky disagreement flag |

## Verification
Every cycle, the assertions check the following:
- Port ownership: reads come only from accepted leading loads, writes only from accepted trailing stores, and never both at once.
- Queues never overflow or underflow.
- Each kind of disagreement raises the flag in the next cycle, and the flag never falls.

Some behaviour only the bench scenarios can show:
- The replayed value is the one memory held at the leading read, not the current one.
- Matched stores write the right address and data.
- Mismatched stores leave memory untouched.
- The ninth store in a row stalls the leading stream until the trailing stream drains one entry.

// File: rtl/rsm_pkg.sv
// Package: shared defaults and types for the redundant stream memory checker.
// Assumes: all modules take widths as parameters and use these values only as defaults.
package rsm_pkg;
    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_DEPTH  = 8;

    // Which side drives the single memory port in a given cycle.
    typedef enum logic [1:0] {
        PORT_IDLE     = 2'd0,
        PORT_LEAD_RD  = 2'd1,
        PORT_TRAIL_WR = 2'd2
    } port_owner_e;
endpackage

// File: rtl/rsm_fifo.sv
// Module: rsm_fifo
// In-order queue with full/empty flags. The oldest entry is always visible on dout.
// Assumes: the caller never pushes when full nor pops when empty; push and pop may
// occur in the same cycle. DEPTH need not be a power of two.
module rsm_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = rsm_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill_cnt;

    assign full  = (fill_cnt == CNT_W'(DEPTH));
    assign empty = (fill_cnt == '0);
    assign dout  = store_q[rd_ptr];

    // Write the incoming entry into its slot.
    always_ff @(posedge clk) begin
        if (push) begin
            store_q[wr_ptr] <= din;
        end
    end

    // Advance pointers and the occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop) begin
                fill_cnt <= fill_cnt + 1'b1;
            end else if (pop && !push) begin
                fill_cnt <= fill_cnt - 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R9
endmodule

// File: rtl/rsm_trail_check.sv
// Module: rsm_trail_check
// Compares each accepted trailing operation with the oldest queued leading record,
// decides whether a trailing store may commit, and holds the sticky error flag.
// Assumes: the *_fire inputs are only high when the matching queue is non-empty.
module rsm_trail_check #(
    parameter int unsigned ADDR_W = rsm_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = rsm_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_fire,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W-1:0] rec_ld_addr,
    input  logic              st_fire,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [ADDR_W-1:0] rec_st_addr,
    input  logic [DATA_W-1:0] rec_st_data,
    input  logic              br_fire,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              rec_br_taken,
    input  logic [ADDR_W-1:0] rec_br_target,
    output logic              st_commit,
    output logic              err_flag
);
    logic ld_bad, st_bad, br_bad;

    // Classify each trailing operation against its recorded counterpart.
    always_comb begin
        ld_bad    = ld_fire && (ld_addr != rec_ld_addr);
        st_bad    = st_fire && ((st_addr != rec_st_addr) || (st_data != rec_st_data));
        br_bad    = br_fire && ((br_taken != rec_br_taken) || (br_target != rec_br_target));
        st_commit = st_fire && !st_bad;
    end

    // Latch any disagreement until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (ld_bad || st_bad || br_bad) begin
            err_flag <= 1'b1;
        end
    end

    AST_STORE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fire && (st_data != rec_st_data)) |=> err_flag);  // R4
    AST_BRANCH_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_fire && (br_target != rec_br_target)) |=> err_flag);  // R6
    AST_LOAD_ADDR_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fire && (ld_addr != rec_ld_addr)) |=> err_flag);  // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);  // R10
endmodule

// File: rtl/rsm_checker.sv
// Module: rsm_checker (top)
// Memory-side checker for a leading and a trailing copy of one program. The leading
// stream reads memory and records values; its stores and branch outcomes are queued.
// The trailing stream replays loads, confirms stores before they reach memory, and
// checks branch outcomes.
// Assumes: memory read data is valid in the same cycle as the address; each stream
// holds its offered operations while its stall output is high.
module rsm_checker #(
    parameter int unsigned ADDR_W = rsm_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = rsm_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = rsm_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_ld_valid,
    input  logic [ADDR_W-1:0] lead_ld_addr,
    output logic [DATA_W-1:0] lead_ld_data,
    input  logic              lead_st_valid,
    input  logic [ADDR_W-1:0] lead_st_addr,
    input  logic [DATA_W-1:0] lead_st_data,
    input  logic              lead_br_valid,
    input  logic              lead_br_taken,
    input  logic [ADDR_W-1:0] lead_br_target,
    output logic              lead_stall,
    input  logic              trail_ld_valid,
    input  logic [ADDR_W-1:0] trail_ld_addr,
    output logic [DATA_W-1:0] trail_ld_data,
    input  logic              trail_st_valid,
    input  logic [ADDR_W-1:0] trail_st_addr,
    input  logic [DATA_W-1:0] trail_st_data,
    input  logic              trail_br_valid,
    input  logic              trail_br_taken,
    input  logic [ADDR_W-1:0] trail_br_target,
    output logic              trail_br_pred_taken,
    output logic [ADDR_W-1:0] trail_br_pred_target,
    output logic              trail_stall,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mismatch_err
);
    import rsm_pkg::*;

    localparam int unsigned REC_W = ADDR_W + DATA_W;
    localparam int unsigned BR_W  = ADDR_W + 1;

    logic             lvq_full, lvq_empty, stb_full, stb_empty, boq_full, boq_empty;
    logic             lvq_push, stb_push, boq_push;
    logic             t_ld_fire, t_st_fire, t_br_fire;
    logic [REC_W-1:0] lvq_head, stb_head;
    logic [BR_W-1:0]  boq_head;
    logic             st_commit;
    port_owner_e      owner;

    // Trailing side: stall when any offered operation finds its queue empty.
    always_comb begin
        trail_stall = (trail_ld_valid && lvq_empty) ||
                      (trail_st_valid && stb_empty) ||
                      (trail_br_valid && boq_empty);
        t_ld_fire   = trail_ld_valid && !trail_stall;
        t_st_fire   = trail_st_valid && !trail_stall;
        t_br_fire   = trail_br_valid && !trail_stall;
    end

    // Leading side: stall on a full queue, or a load colliding with a trailing store.
    always_comb begin
        lead_stall = (lead_ld_valid && (lvq_full || t_st_fire)) ||
                     (lead_st_valid && stb_full) ||
                     (lead_br_valid && boq_full);
        lvq_push   = lead_ld_valid && !lead_stall;
        stb_push   = lead_st_valid && !lead_stall;
        boq_push   = lead_br_valid && !lead_stall;
    end

    rsm_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_load_replay (
        .clk(clk), .rst_n(rst_n),
        .push(lvq_push), .din({lead_ld_addr, mem_rdata}),
        .pop(t_ld_fire), .dout(lvq_head),
        .full(lvq_full), .empty(lvq_empty)
    );

    rsm_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_store_hold (
        .clk(clk), .rst_n(rst_n),
        .push(stb_push), .din({lead_st_addr, lead_st_data}),
        .pop(t_st_fire), .dout(stb_head),
        .full(stb_full), .empty(stb_empty)
    );

    rsm_fifo #(.WIDTH(BR_W), .DEPTH(DEPTH)) u_branch_queue (
        .clk(clk), .rst_n(rst_n),
        .push(boq_push), .din({lead_br_taken, lead_br_target}),
        .pop(t_br_fire), .dout(boq_head),
        .full(boq_full), .empty(boq_empty)
    );

    rsm_trail_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_compare (
        .clk(clk), .rst_n(rst_n),
        .ld_fire(t_ld_fire), .ld_addr(trail_ld_addr),
        .rec_ld_addr(lvq_head[REC_W-1 -: ADDR_W]),
        .st_fire(t_st_fire), .st_addr(trail_st_addr), .st_data(trail_st_data),
        .rec_st_addr(stb_head[REC_W-1 -: ADDR_W]),
        .rec_st_data(stb_head[DATA_W-1:0]),
        .br_fire(t_br_fire), .br_taken(trail_br_taken), .br_target(trail_br_target),
        .rec_br_taken(boq_head[BR_W-1]),
        .rec_br_target(boq_head[ADDR_W-1:0]),
        .st_commit(st_commit), .err_flag(mismatch_err)
    );

    // Replayed data and predictions come straight from the queue heads.
    always_comb begin
        lead_ld_data         = mem_rdata;
        trail_ld_data        = lvq_head[DATA_W-1:0];
        trail_br_pred_taken  = boq_head[BR_W-1];
        trail_br_pred_target = boq_head[ADDR_W-1:0];
    end

    // Choose the owner of the single memory port for this cycle.
    always_comb begin
        if (st_commit) begin
            owner = PORT_TRAIL_WR;
        end else if (lvq_push) begin
            owner = PORT_LEAD_RD;
        end else begin
            owner = PORT_IDLE;
        end
    end

    // Drive the memory port according to its owner.
    always_comb begin
        mem_rd_en = (owner == PORT_LEAD_RD);
        mem_wr_en = (owner == PORT_TRAIL_WR);
        mem_wdata = trail_st_data;
        unique case (owner)
            PORT_TRAIL_WR: mem_addr = trail_st_addr;
            PORT_LEAD_RD:  mem_addr = lead_ld_addr;
            default:       mem_addr = lead_ld_addr;
        endcase
    end

    AST_RD_ONLY_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (lead_ld_valid && !lead_stall));  // R1
    AST_WR_ONLY_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (trail_st_valid && !trail_stall));  // R3
    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));  // R11
endmodule

// File: tb/sim_rsm_checker.sv
`timescale 1ns/100ps
// Bench: scoreboard-driven test of rsm_checker with a behavioural memory model.
module sim_rsm_checker;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          lead_ld_valid, lead_st_valid, lead_br_valid, lead_br_taken;
    logic [AW-1:0] lead_ld_addr, lead_st_addr, lead_br_target;
    logic [DW-1:0] lead_st_data, lead_ld_data;
    logic          lead_stall;
    logic          trail_ld_valid, trail_st_valid, trail_br_valid, trail_br_taken;
    logic [AW-1:0] trail_ld_addr, trail_st_addr, trail_br_target;
    logic [DW-1:0] trail_st_data, trail_ld_data;
    logic          trail_br_pred_taken, trail_stall;
    logic [AW-1:0] trail_br_pred_target;
    logic          mem_rd_en, mem_wr_en, mismatch_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] memory [256];

    int n_chk = 0;
    int n_fail = 0;

    // Scoreboard queues: replayed load data, branch outcomes, held stores, expected writes.
    logic [DW-1:0]      exp_ld_q [$];
    logic [AW:0]        exp_br_q [$];
    logic [AW+DW-1:0]   exp_st_q [$];
    logic [AW+DW-1:0]   exp_wr_q [$];

    rsm_checker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lead_ld_valid(lead_ld_valid), .lead_ld_addr(lead_ld_addr), .lead_ld_data(lead_ld_data),
        .lead_st_valid(lead_st_valid), .lead_st_addr(lead_st_addr), .lead_st_data(lead_st_data),
        .lead_br_valid(lead_br_valid), .lead_br_taken(lead_br_taken), .lead_br_target(lead_br_target),
        .lead_stall(lead_stall),
        .trail_ld_valid(trail_ld_valid), .trail_ld_addr(trail_ld_addr), .trail_ld_data(trail_ld_data),
        .trail_st_valid(trail_st_valid), .trail_st_addr(trail_st_addr), .trail_st_data(trail_st_data),
        .trail_br_valid(trail_br_valid), .trail_br_taken(trail_br_taken), .trail_br_target(trail_br_target),
        .trail_br_pred_taken(trail_br_pred_taken), .trail_br_pred_target(trail_br_pred_target),
        .trail_stall(trail_stall),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mismatch_err(mismatch_err)
    );

    assign mem_rdata = memory[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr_en) memory[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: every memory write must match the next expected write (R3).
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && mem_wr_en) begin
                if (exp_wr_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {16'h0, mem_addr, mem_wdata}, 64'h0);
                end else begin
                    logic [AW+DW-1:0] w;
                    w = exp_wr_q.pop_front();
                    chk({mem_addr, mem_wdata} == w, "R3 write addr/data",
                        {16'h0, mem_addr, mem_wdata}, {16'h0, w});
                end
            end
        end
    end

    task automatic clear_inputs();
        lead_ld_valid = 0; lead_st_valid = 0; lead_br_valid = 0; lead_br_taken = 0;
        lead_ld_addr = 0; lead_st_addr = 0; lead_st_data = 0; lead_br_target = 0;
        trail_ld_valid = 0; trail_st_valid = 0; trail_br_valid = 0; trail_br_taken = 0;
        trail_ld_addr = 0; trail_st_addr = 0; trail_st_data = 0; trail_br_target = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_inputs();
        exp_ld_q.delete(); exp_br_q.delete(); exp_st_q.delete(); exp_wr_q.delete();
        for (int i = 0; i < 256; i++) memory[i] = DW'(i * 3 + 7);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // Driver: one leading operation group; records expected items for the trailing side.
    task automatic lead_cycle(input bit ldv, input logic [AW-1:0] la,
                              input bit stv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                              input bit brv, input bit bt, input logic [AW-1:0] bg);
        @(negedge clk);
        lead_ld_valid = ldv; lead_ld_addr = la;
        lead_st_valid = stv; lead_st_addr = sa; lead_st_data = sd;
        lead_br_valid = brv; lead_br_taken = bt; lead_br_target = bg;
        #0.5;
        while (lead_stall) begin @(negedge clk); #0.5; end
        if (ldv) begin
            chk(mem_rd_en == 1'b1, "R1 read enable", 64'(mem_rd_en), 64'h1);
            chk(lead_ld_data == memory[la[7:0]], "R1 lead data", 64'(lead_ld_data), 64'(memory[la[7:0]]));
            exp_ld_q.push_back(lead_ld_data);
        end
        if (stv) begin
            chk(mem_wr_en == 1'b0, "R3 lead store no write", 64'(mem_wr_en), 64'h0);
            exp_st_q.push_back({sa, sd});
        end
        if (brv) exp_br_q.push_back({bt, bg});
        @(posedge clk);
        #1;
        lead_ld_valid = 0; lead_st_valid = 0; lead_br_valid = 0;
    endtask

    // Driver: one trailing operation group; checks replay data and predictions.
    task automatic trail_cycle(input bit ldv, input logic [AW-1:0] la,
                               input bit stv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                               input bit brv, input bit bt, input logic [AW-1:0] bg);
        @(negedge clk);
        trail_ld_valid = ldv; trail_ld_addr = la;
        trail_st_valid = stv; trail_st_addr = sa; trail_st_data = sd;
        trail_br_valid = brv; trail_br_taken = bt; trail_br_target = bg;
        #0.5;
        while (trail_stall) begin @(negedge clk); #0.5; end
        if (ldv) begin
            logic [DW-1:0] e;
            e = exp_ld_q.pop_front();
            chk(trail_ld_data == e, "R2 replayed data", 64'(trail_ld_data), 64'(e));
        end
        if (brv) begin
            logic [AW:0] b;
            b = exp_br_q.pop_front();
            chk({trail_br_pred_taken, trail_br_pred_target} == b, "R5 branch prediction",
                64'({trail_br_pred_taken, trail_br_pred_target}), 64'(b));
        end
        if (stv) begin
            logic [AW+DW-1:0] s;
            s = exp_st_q.pop_front();
            if (s == {sa, sd}) exp_wr_q.push_back(s);
            else chk(mem_wr_en == 1'b0, "R4 mismatched store not written", 64'(mem_wr_en), 64'h0);
        end
        @(posedge clk);
        #1;
        trail_ld_valid = 0; trail_st_valid = 0; trail_br_valid = 0;
    endtask

    task automatic chk_err(input bit e, input string req);
        @(negedge clk);
        chk(mismatch_err == e, req, 64'(mismatch_err), 64'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'h0, 64'h1);
        report();
    end

    initial begin
        clear_inputs();
        do_reset();

        // R10: reset state
        #0.5;
        chk(mismatch_err == 0, "R10 reset error", 64'(mismatch_err), 0);
        chk(lead_stall == 0 && trail_stall == 0, "R10 reset stalls", 64'({lead_stall, trail_stall}), 0);
        chk(mem_rd_en == 0 && mem_wr_en == 0, "R10 reset enables", 64'({mem_rd_en, mem_wr_en}), 0);

        // R1 R2 R5 R3: normal flow; memory changes after the leading read
        lead_cycle(1, 16'd5, 0, 0, 0, 1, 1, 16'h0040);
        lead_cycle(1, 16'd9, 1, 16'd5, 32'hAAAA_0001, 1, 0, 16'h0088);
        memory[9] = 32'hDEAD_BEEF;
        trail_cycle(1, 16'd5, 0, 0, 0, 1, 1, 16'h0040);
        trail_cycle(1, 16'd9, 1, 16'd5, 32'hAAAA_0001, 1, 0, 16'h0088);
        lead_cycle(1, 16'd5, 0, 0, 0, 0, 0, 0);
        chk(exp_ld_q[0] == 32'hAAAA_0001, "R3 committed store visible", 64'(exp_ld_q[0]), 64'hAAAA_0001);
        trail_cycle(1, 16'd5, 0, 0, 0, 0, 0, 0);
        chk_err(0, "R2 no error on matching flow");

        // R4 R10: store mismatch is dropped and the flag sticks
        do_reset();
        lead_cycle(0, 0, 1, 16'd3, 32'h55, 0, 0, 0);
        trail_cycle(0, 0, 1, 16'd3, 32'h56, 0, 0, 0);
        chk_err(1, "R4 store data mismatch");
        chk(memory[3] == 32'd16, "R4 memory untouched", 64'(memory[3]), 64'd16);
        repeat (5) @(posedge clk);
        chk_err(1, "R10 error sticky");

        // R6: branch mismatch
        do_reset();
        lead_cycle(0, 0, 0, 0, 0, 1, 1, 16'h0010);
        chk_err(0, "R6 no error before trailing branch");
        trail_cycle(0, 0, 0, 0, 0, 1, 0, 16'h0010);
        chk_err(1, "R6 branch taken mismatch");

        // R7: load address mismatch still returns recorded data
        do_reset();
        lead_cycle(1, 16'd7, 0, 0, 0, 0, 0, 0);
        trail_cycle(1, 16'd8, 0, 0, 0, 0, 0, 0);
        chk_err(1, "R7 load address mismatch");

        // R9: trailing stall on empty queues
        do_reset();
        @(negedge clk);
        trail_st_valid = 1; trail_st_addr = 16'd1; trail_st_data = 32'h1;
        #0.5;
        chk(trail_stall == 1, "R9 stall on empty store queue", 64'(trail_stall), 1);
        chk(mem_wr_en == 0, "R9 no write while stalled", 64'(mem_wr_en), 0);
        @(posedge clk); #1; trail_st_valid = 0;

        // R8: fill the store queue, the next store stalls until one drains
        for (int i = 0; i < DEPTH; i++) lead_cycle(0, 0, 1, 16'(20 + i), 32'(100 + i), 0, 0, 0);
        @(negedge clk);
        lead_st_valid = 1; lead_st_addr = 16'd40; lead_st_data = 32'd999;
        #0.5;
        chk(lead_stall == 1, "R8 stall on full store queue", 64'(lead_stall), 1);
        @(posedge clk); #1; lead_st_valid = 0;
        trail_cycle(0, 0, 1, 16'd20, 32'd100, 0, 0, 0);
        lead_cycle(0, 0, 1, 16'd40, 32'd999, 0, 0, 0);
        for (int i = 1; i < DEPTH; i++) trail_cycle(0, 0, 1, 16'(20 + i), 32'(100 + i), 0, 0, 0);
        trail_cycle(0, 0, 1, 16'd40, 32'd999, 0, 0, 0);
        chk_err(0, "R8 drained in order without error");
        chk(memory[40] == 32'd999, "R8 released store written", 64'(memory[40]), 64'd999);

        // R11: trailing store and leading load in the same cycle
        do_reset();
        lead_cycle(0, 0, 1, 16'd2, 32'h77, 0, 0, 0);
        @(negedge clk);
        exp_st_q.delete();
        exp_wr_q.push_back({16'd2, 32'h77});
        lead_ld_valid = 1; lead_ld_addr = 16'd4;
        trail_st_valid = 1; trail_st_addr = 16'd2; trail_st_data = 32'h77;
        #0.5;
        chk(lead_stall == 1, "R11 leading load stalled", 64'(lead_stall), 1);
        chk(mem_wr_en == 1 && mem_rd_en == 0, "R11 write owns port", 64'({mem_wr_en, mem_rd_en}), 64'h2);
        @(posedge clk); #1; trail_st_valid = 0;
        @(negedge clk); #0.5;
        chk(lead_stall == 0 && mem_rd_en == 1, "R11 load proceeds next cycle", 64'({lead_stall, mem_rd_en}), 64'h1);
        chk(lead_ld_data == 32'd19, "R1 load data after contention", 64'(lead_ld_data), 64'd19);
        @(posedge clk); #1; lead_ld_valid = 0;

        repeat (3) @(posedge clk);
        chk(exp_wr_q.size() == 0, "R3 all expected writes seen", 64'(exp_wr_q.size()), 0);
        report();
    end
endmodule